// File: doc/BRIEF.md
# Programmable Binary Timer/Divider

This block counts qualified clock ticks in a 16-stage binary counter and drives one output bit from a chosen counter stage. A two-bit select input picks which stage is used. The stage number N is 8, 10, 13 or 16, so the divide ratio is 2^N. The block has two modes. In recycle mode the output is a continuous square wave at the tick rate divided by 2^N. In single-transition mode the output makes exactly one transition, 2^(N-1) ticks after timing starts, and then stays in the new level. An invert input sets the level the output takes after any reset.

Timing can start in two ways. When the auto-reset feature is enabled, a synchronous power-on pulse initialises the block and counting starts on its own. When the feature is disabled, the block waits after power-on until a master reset pulse has gone high and come back low. While the master reset is high, the counter is held at zero and ticks are ignored. All behaviour is sequenced by a four-state controller:

- WAIT: armed, waiting for the first master reset.
- HOLD: master reset in effect.
- RUN: counting.
- FIRED: the single-transition output has latched.

The controller has these transitions:

- power-on with auto-reset enabled goes to RUN;
- power-on with auto-reset disabled goes to WAIT;
- master reset high goes to HOLD from any state;
- HOLD goes to RUN once master reset is low;
- RUN goes to FIRED on the tick where the selected stage bit first rises in single-transition mode;
- FIRED goes back to RUN when recycle mode is selected.

Top module: `prog_timer`

## Requirements
- R1: While in RUN or FIRED, the counter advances by exactly one on each clock edge where `tick_en` is 1. Clock edges where `tick_en` is 0 leave it unchanged (R11).
- R2: `sel` maps to the stage number N as follows: 2'b00 gives N=13, 2'b01 gives N=10, 2'b10 gives N=8, 2'b11 gives N=16.
- R3: With `recycle`=1, `timer_out` equals bit N-1 of the tick count since timing started, XOR `invert`. This gives a square wave with a period of 2^N ticks.
- R4: With `recycle`=0, `timer_out` (with `invert`=0) goes from 0 to 1 right after the edge that counts tick number 2^(N-1). It then stays at 1 while the counter keeps running.
- R5: Setting `recycle`=1 clears the single-transition latch. If `recycle` later returns to 0, the output stays low until the selected stage bit next rises.
- R6: After any reset, `timer_out` equals `invert`. `invert`=1 inverts the output in both modes.
- R7: While `master_rst` is 1, the counter is zero and ticks are ignored. The clock edge on which `master_rst` is first seen low also counts nothing. Counting resumes on the edge after it.
- R8: After a power-on pulse with `auto_off`=0, the first tick after `por` falls is counted as tick 1.
- R9: After a power-on pulse with `auto_off`=1, ticks are ignored until `master_rst` has been high and then low again.
- R10: A change of `sel` takes effect immediately on the output and does not clear the counter.
- R11: Clock edges with `tick_en`=0 never change the count or the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on pulse, active high; initialises all state |
| auto_off | input | 1 | 1 disables automatic start after power-on |
| master_rst | input | 1 | Master reset, active high |
| tick_en | input | 1 | Qualified count tick, one clock wide per count |
| sel | input | 2 | Stage select (see R2) |
| recycle | input | 1 | 1 selects recycle mode, 0 selects single-transition mode |
| invert | input | 1 | Output polarity; sets the post-reset output level |
| timer_out | output | 1 | Timer output |

## Verification
The bench aims at the exact tick where the single transition happens for every select code. A design that is off by one stage, or that tests the wrong counter bit, fires twice as early or twice as late as it should. The bench also checks the edge right after master reset is released: a design that counts on that edge runs one tick ahead for the whole run. It holds off ticks after a power-on with auto-start disabled, where a design that counts anyway toggles the output early. Finally, it changes mode and select mid-run; a latch that survives the switch to recycle mode, or a counter that is cleared when the select changes, shows a wrong output level.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_RUN   = 2'd2,
        ST_FIRED = 2'd3
    } tmr_state_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_inc
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assign cnt_inc = cnt + ONE;

    always_ff @(posedge clk) begin
        if (por || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt_inc;
        end
    end
endmodule

// File: rtl/tmr_tap_sel.sv
module tmr_tap_sel #(
    parameter int CNT_W = 16,
    parameter int N_SEL0 = 13,
    parameter int N_SEL1 = 10,
    parameter int N_SEL2 = 8,
    parameter int N_SEL3 = 16
) (
    input  logic [1:0]       sel,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cnt_inc,
    output logic             tap_now,
    output logic             tap_next
);
    localparam int NUM_SEL = 4;

    logic [NUM_SEL-1:0] now_v;
    logic [NUM_SEL-1:0] nxt_v;

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_tap
        localparam int STAGE = (i == 0) ? N_SEL0 :
                               (i == 1) ? N_SEL1 :
                               (i == 2) ? N_SEL2 : N_SEL3;
        assign now_v[i] = cnt[STAGE-1];
        assign nxt_v[i] = cnt_inc[STAGE-1];
    end

    assign tap_now  = now_v[sel];
    assign tap_next = nxt_v[sel];

    logic unused_cnt_bits;
    assign unused_cnt_bits = ^{cnt, cnt_inc};
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  logic       auto_off,
    input  logic       master_rst,
    input  logic       tick_en,
    input  logic       recycle,
    input  logic       tap_now,
    input  logic       tap_next,
    output tmr_state_e state_q,
    output logic       count_en,
    output logic       count_clr,
    output logic       fired
);
    tmr_state_e state_nx;
    logic       tap_rise;

    assign tap_rise = tick_en && !tap_now && tap_next;

    // state register
    always_ff @(posedge clk) begin
        if (por) begin
            state_q <= auto_off ? ST_WAIT : ST_RUN;
        end else begin
            state_q <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        if (master_rst) begin
            state_nx = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_WAIT:  state_nx = ST_WAIT;
                ST_HOLD:  state_nx = ST_RUN;
                ST_RUN:   if (!recycle && tap_rise) state_nx = ST_FIRED;
                ST_FIRED: if (recycle) state_nx = ST_RUN;
            endcase
        end
    end

    // outputs
    always_comb begin
        count_en  = 1'b0;
        count_clr = master_rst;
        fired     = 1'b0;
        unique case (state_q)
            ST_WAIT:  count_clr = 1'b1;
            ST_HOLD:  count_clr = 1'b1;
            ST_RUN:   count_en  = tick_en;
            ST_FIRED: begin
                count_en = tick_en;
                fired    = 1'b1;
            end
        endcase
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (por)
        (state_q == ST_FIRED && !master_rst && !recycle) |=> state_q == ST_FIRED) // R4
        else $error("latch dropped");

    AST_RECYCLE_CLEARS: assert property (@(posedge clk) disable iff (por)
        (state_q == ST_FIRED && !master_rst && recycle) |=> state_q == ST_RUN) // R5
        else $error("latch kept in recycle");

    AST_WAIT_STAYS: assert property (@(posedge clk) disable iff (por)
        (state_q == ST_WAIT && !master_rst) |=> state_q == ST_WAIT) // R9
        else $error("left wait without reset");

    AST_NO_FIRE_RECYCLE: assert property (@(posedge clk) disable iff (por)
        (recycle && state_q != ST_FIRED) |=> state_q != ST_FIRED) // R5
        else $error("fired in recycle");
endmodule

// File: rtl/prog_timer.sv
module prog_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_SEL0 = 13,
    parameter int N_SEL1 = 10,
    parameter int N_SEL2 = 8,
    parameter int N_SEL3 = 16
) (
    input  logic       clk,
    input  logic       por,
    input  logic       auto_off,
    input  logic       master_rst,
    input  logic       tick_en,
    input  logic [1:0] sel,
    input  logic       recycle,
    input  logic       invert,
    output logic       timer_out
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic             tap_now;
    logic             tap_next;
    logic             count_en;
    logic             count_clr;
    logic             fired;
    tmr_state_e       state;

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .por     (por),
        .clr     (count_clr),
        .en      (count_en),
        .cnt     (cnt),
        .cnt_inc (cnt_inc)
    );

    tmr_tap_sel #(
        .CNT_W (CNT_W),
        .N_SEL0(N_SEL0),
        .N_SEL1(N_SEL1),
        .N_SEL2(N_SEL2),
        .N_SEL3(N_SEL3)
    ) u_tap (
        .sel      (sel),
        .cnt      (cnt),
        .cnt_inc  (cnt_inc),
        .tap_now  (tap_now),
        .tap_next (tap_next)
    );

    tmr_ctrl u_ctrl (
        .clk        (clk),
        .por        (por),
        .auto_off   (auto_off),
        .master_rst (master_rst),
        .tick_en    (tick_en),
        .recycle    (recycle),
        .tap_now    (tap_now),
        .tap_next   (tap_next),
        .state_q    (state),
        .count_en   (count_en),
        .count_clr  (count_clr),
        .fired      (fired)
    );

    assign timer_out = (recycle ? tap_now : fired) ^ invert;

    AST_MR_ZERO: assert property (@(posedge clk) disable iff (por)
        master_rst |=> cnt == '0) // R7
        else $error("count not cleared by master reset");

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (por)
        (!master_rst && tick_en && (state == ST_RUN || state == ST_FIRED))
        |=> cnt == $past(cnt) + 1'b1) // R1
        else $error("count did not step");

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (por)
        (!master_rst && !tick_en) |=> $stable(cnt)) // R11
        else $error("count moved without tick");

    AST_WAIT_ZERO: assert property (@(posedge clk) disable iff (por)
        (state == ST_WAIT && !master_rst) |=> cnt == '0) // R9
        else $error("counted before first master reset");

    always_ff @(posedge clk) begin
        if (!por && state == ST_HOLD) begin
            AST_RESET_LEVEL: assert (timer_out == invert) // R6
                else $error("wrong level during reset");
        end
    end
endmodule

// File: tb/prog_timer_bench.sv
module prog_timer_bench;
    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       auto_off = 1'b0;
    logic       master_rst = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] sel = 2'b10;
    logic       recycle = 1'b1;
    logic       invert = 1'b0;
    logic       timer_out;

    int    total = 0;
    int    bad = 0;
    int    k = 0;
    bit    fired_m = 1'b0;
    bit    running = 1'b0;
    string cur_req = "R6";

    always #5 clk = ~clk;

    prog_timer u_prog_timer (
        .clk        (clk),
        .por        (por),
        .auto_off   (auto_off),
        .master_rst (master_rst),
        .tick_en    (tick_en),
        .sel        (sel),
        .recycle    (recycle),
        .invert     (invert),
        .timer_out  (timer_out)
    );

    // R2: select code to stage number
    function automatic int sel_n(input logic [1:0] s);
        case (s)
            2'b00:   return 13;
            2'b01:   return 10;
            2'b10:   return 8;
            default: return 16;
        endcase
    endfunction

    function automatic bit stage_bit(input int v, input int n);
        return bit'((v >> (n - 1)) & 1);
    endfunction

    function automatic logic expect_out();
        logic b;
        b = recycle ? stage_bit(k, sel_n(sel)) : fired_m;
        return b ^ invert;
    endfunction

    task automatic check(input logic exp_v);
        total++;
        if (timer_out !== exp_v) begin
            bad++;
            $display("FAIL %s: timer_out=%0b expected=%0b (sel=%0b recycle=%0b k=%0d)",
                     cur_req, timer_out, exp_v, sel, recycle, k);
        end
    endtask

    task automatic step(input logic te);
        int prev;
        @(negedge clk);
        tick_en = te;
        @(posedge clk);
        prev = k;
        if (running && te) k = (k + 1) & 32'hFFFF;
        if (recycle) fired_m = 1'b0;
        else if (running && te && !stage_bit(prev, sel_n(sel)) && stage_bit(k, sel_n(sel)))
            fired_m = 1'b1;
        #1;
        check(expect_out());
    endtask

    task automatic run_ticks(input int count, input bit dense);
        int done_t;
        done_t = 0;
        while (done_t < count) begin
            logic te;
            te = dense ? 1'b1 : logic'($urandom % 2);
            step(te);
            if (te) done_t++;
        end
    endtask

    // R7: ticks during master reset and on the release edge are not counted
    task automatic do_mr();
        string saved;
        saved = cur_req;
        cur_req = "R7";
        @(negedge clk);
        master_rst = 1'b1;
        tick_en = 1'b1;
        for (int i = 0; i < 2; i++) begin
            @(posedge clk);
            #1;
            check(invert);
        end
        @(negedge clk);
        master_rst = 1'b0;
        @(posedge clk);
        #1;
        k = 0;
        fired_m = 1'b0;
        running = 1'b1;
        check(invert);
        cur_req = saved;
    endtask

    task automatic do_por(input logic off);
        @(negedge clk);
        por = 1'b1;
        auto_off = off;
        tick_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        por = 1'b0;
        k = 0;
        fired_m = 1'b0;
        running = !off;
        cur_req = "R6";
        check(invert);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd4541));
        // reset state, auto start (R8)
        do_por(1'b0);
        cur_req = "R8";
        step(1'b1);
        step(1'b1);
        // R1 R3 R11: random ticks, recycle, N=8
        cur_req = "R1 R3 R11";
        run_ticks(600, 1'b0);
        // R10: select change mid-run keeps the count
        sel = 2'b01;
        cur_req = "R10";
        run_ticks(1200, 1'b0);
        sel = 2'b10;
        run_ticks(100, 1'b0);

        // R2 R4 R3 R5 R6 over every select and polarity
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 2; v++) begin
                sel = s[1:0];
                invert = v[0];
                recycle = 1'b0;
                n = sel_n(sel);
                do_mr();
                cur_req = "R2 R4 R6";
                run_ticks((1 << (n - 1)) + 20, n >= 13);
                recycle = 1'b1;
                cur_req = "R3 R6";
                if (!(n == 16 && v == 1))
                    run_ticks((1 << (n - 1)) + 20, n >= 13);
                recycle = 1'b0;
                cur_req = "R5";
                run_ticks(20, 1'b0);
            end
        end

        // R9: auto start disabled
        sel = 2'b10;
        invert = 1'b0;
        recycle = 1'b1;
        do_por(1'b1);
        cur_req = "R9";
        run_ticks(300, 1'b1);
        do_mr();
        cur_req = "R9";
        run_ticks(300, 1'b1);

        // R8: auto start enabled, counting from the first tick
        do_por(1'b0);
        cur_req = "R8";
        run_ticks(300, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule